// File: doc/BRIEF.md
# Processor exception entry controller

This block owns a processor's status word together with five banks of saved-status and link registers. The banks belong to supervisor, undefined, abort, normal-interrupt and fast-interrupt mode. Each cycle it looks at the pending exception sources and picks at most one winner. Interrupts are qualified by the instruction-boundary strobe and by their mask bits. Instruction-sourced faults are qualified by the execute-valid flag. For the winner, the block switches the mode field and updates the mask bits. It stores the old status word and a return link in the target bank, and it emits the address the fetch unit must jump to.

It also carries out exception return. A return restores the status word from the current mode's saved copy and redirects fetch to the banked link minus an adjustment chosen by the caller. A plain status write path lets software set the mode and masks. A synchronous active-low reset is itself treated as the highest-priority exception. All outputs are registered, so an event accepted at one clock edge is visible on the ports just after that edge.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, on each clock edge the block shows a reset entry: `entry_o`=1, `exc_code_o`=0, and `target_o` set to the vector base. The base is 0x00000000, or 0xFFFF0000 when `hivec_i` is 1. `status_o` = 0x1D3 with bit 9 taken from `endian_i`. The supervisor bank is not written.
- R2: An entry's `target_o` is the base plus 4 times the code. The codes are: undefined 1, software interrupt 2, prefetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7.
- R3: On entry, `status_o[4:0]` takes the target mode. The modes are: undefined 0b11011, software interrupt 0b10011, either abort 0b10111, normal interrupt 0b10010, fast interrupt 0b10001. Bit 5 is cleared, bit 7 is set, and bit 9 is loaded from `endian_i`. All other bits are kept.
- R4: Bit 6 is set on fast-interrupt entry and kept on every other entry.
- R5: Bit 8 is set on abort and interrupt entries and kept on undefined and software-interrupt entries.
- R6: The link stored on entry is `pc_i`+8 for a data abort and `pc_i`+4 for every other type. `pc_i` is the faulting instruction for faults, or the next instruction to run for interrupts.
- R7: On entry, the previous status word goes into the target bank's saved status. `saved_o` and `link_o` show the bank of the current mode, and read 0 in a mode without a bank.
- R8: A normal interrupt is taken only when `bnd_i`=1 and status bit 7 is 0. A fast interrupt is taken only when `bnd_i`=1 and status bit 6 is 0.
- R9: With `vic_en_i`=1, both interrupt types jump to `vic_addr_i` instead of their slot.
- R10: Undefined, software-interrupt and prefetch-abort requests take effect only when `exec_i`=1. A flushed request leaves the status and outputs untouched.
- R11: Priority is data abort, then fast interrupt, normal interrupt, prefetch abort, undefined, and software interrupt. One event is accepted per cycle. A return or status write requested in the same cycle as an entry is dropped.
- R12: A return (`ret_i`=1) with `ret_adj_i` 0, 1 or 2 copies the current bank's saved status into `status_o`. It sets `target_o` to the link minus 0, 4 or 8 and pulses `return_o`.
- R13: A return in a mode without a bank, or with `ret_adj_i`=3, pulses `ret_err_o` and leaves the status unchanged and `return_o` at 0.
- R14: With no entry or return accepted, `wr_i`=1 loads all of `status_o` from `wr_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, handled as the reset exception |
| pc_i | input | XLEN | Faulting instruction address, or next instruction at a boundary |
| exec_i | input | 1 | Instruction in execute really executes |
| bnd_i | input | 1 | Instruction boundary strobe |
| und_i | input | 1 | Undefined instruction request |
| swi_i | input | 1 | Software interrupt request |
| pabt_i | input | 1 | Instruction flagged by a fetch abort |
| dabt_i | input | 1 | Data access abort |
| irq_i | input | 1 | Normal interrupt line |
| fiq_i | input | 1 | Fast interrupt line |
| hivec_i | input | 1 | Select high vector base |
| endian_i | input | 1 | Endianness value loaded into bit 9 on entry |
| vic_en_i | input | 1 | Use external interrupt vector |
| vic_addr_i | input | XLEN | External interrupt vector |
| ret_i | input | 1 | Exception return request |
| ret_adj_i | input | 2 | Return adjustment code (0, 4 or 8 bytes) |
| wr_i | input | 1 | Status write enable |
| wr_data_i | input | XLEN | Status write data |
| status_o | output | XLEN | Current status word |
| saved_o | output | XLEN | Saved status of the current mode |
| link_o | output | XLEN | Link register of the current mode |
| entry_o | output | 1 | Exception entry accepted |
| exc_code_o | output | 3 | Code of the last entry |
| return_o | output | 1 | Return accepted |
| ret_err_o | output | 1 | Return refused |
| target_o | output | XLEN | New fetch address after entry or return |

## Verification
The hardest states to reach are those where an interrupt is actually unmasked. Reset and every entry set the normal-interrupt mask, so no sequence of entries and returns alone can ever clear it. The stimulus therefore first uses the status write path to place the block in user mode with all masks clear. Each entry is then followed by a return, so that the next scenario starts unmasked. Masked cases are reached the same way: one by writing a status with only the fast mask set, the other by raising a normal interrupt while the fast handler is active.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_i,
  input  logic            exec_i,
  input  logic            bnd_i,
  input  logic            und_i,
  input  logic            swi_i,
  input  logic            pabt_i,
  input  logic            dabt_i,
  input  logic            irq_i,
  input  logic            fiq_i,
  input  logic            hivec_i,
  input  logic            endian_i,
  input  logic            vic_en_i,
  input  logic [XLEN-1:0] vic_addr_i,
  input  logic            ret_i,
  input  logic [1:0]      ret_adj_i,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] saved_o,
  output logic [XLEN-1:0] link_o,
  output logic            entry_o,
  output logic [2:0]      exc_code_o,
  output logic            return_o,
  output logic            ret_err_o,
  output logic [XLEN-1:0] target_o
);

  localparam int NBANK = 5;
  localparam int BW    = $clog2(NBANK);

  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_FIQ = 5'b10001;

  localparam logic [2:0] C_RST = 3'd0;
  localparam logic [2:0] C_UND = 3'd1;
  localparam logic [2:0] C_SWI = 3'd2;
  localparam logic [2:0] C_PAB = 3'd3;
  localparam logic [2:0] C_DAB = 3'd4;
  localparam logic [2:0] C_IRQ = 3'd6;
  localparam logic [2:0] C_FIQ = 3'd7;

  localparam logic [XLEN-1:0] RST_ST = XLEN'(10'h1D3);

  function automatic logic [BW:0] bank_of(input logic [4:0] m);
    case (m)
      M_SVC:   bank_of = {1'b1, BW'(0)};
      M_UND:   bank_of = {1'b1, BW'(1)};
      M_ABT:   bank_of = {1'b1, BW'(2)};
      M_IRQ:   bank_of = {1'b1, BW'(3)};
      M_FIQ:   bank_of = {1'b1, BW'(4)};
      default: bank_of = '0;
    endcase
  endfunction

  logic [XLEN-1:0] st_q;
  logic [XLEN-1:0] spsr_q [NBANK];
  logic [XLEN-1:0] lr_q   [NBANK];
  logic            entry_q, return_q, err_q;
  logic [2:0]      code_q;
  logic [XLEN-1:0] tgt_q;

  logic            take;
  logic [2:0]      code;
  logic [4:0]      mode;
  logic [XLEN-1:0] link, nst, vec;
  logic [BW:0]     tbank, cbank;
  logic            ret_ok, ret_bad;

  wire fiq_ok = fiq_i & bnd_i & ~st_q[6];
  wire irq_ok = irq_i & bnd_i & ~st_q[7];
  wire [XLEN-1:0] base = hivec_i ? XLEN'(HI_BASE) : '0;

  always_comb begin
    take = 1'b1;
    code = C_RST;
    mode = M_SVC;
    link = pc_i + XLEN'(4);
    if (dabt_i) begin
      code = C_DAB; mode = M_ABT; link = pc_i + XLEN'(8);
    end else if (fiq_ok) begin
      code = C_FIQ; mode = M_FIQ;
    end else if (irq_ok) begin
      code = C_IRQ; mode = M_IRQ;
    end else if (pabt_i && exec_i) begin
      code = C_PAB; mode = M_ABT;
    end else if (und_i && exec_i) begin
      code = C_UND; mode = M_UND;
    end else if (swi_i && exec_i) begin
      code = C_SWI; mode = M_SVC;
    end else begin
      take = 1'b0;
    end

    nst      = st_q;
    nst[4:0] = mode;
    nst[5]   = 1'b0;
    nst[6]   = st_q[6] | (code == C_FIQ);
    nst[7]   = 1'b1;
    nst[8]   = st_q[8] | ~((code == C_UND) || (code == C_SWI));
    nst[9]   = endian_i;

    if (vic_en_i && (code == C_IRQ || code == C_FIQ)) vec = vic_addr_i;
    else vec = base | XLEN'({code, 2'b00});
  end

  assign tbank   = bank_of(mode);
  assign cbank   = bank_of(st_q[4:0]);
  assign ret_ok  = ret_i & ~take & cbank[BW] & (ret_adj_i != 2'd3);
  assign ret_bad = ret_i & ~take & ~ret_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= RST_ST | (XLEN'(endian_i) << 9);
      entry_q  <= 1'b1;
      code_q   <= C_RST;
      tgt_q    <= base;
      return_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      entry_q  <= take;
      return_q <= ret_ok;
      err_q    <= ret_bad;
      if (take) begin
        st_q   <= nst;
        code_q <= code;
        tgt_q  <= vec;
      end else if (ret_ok) begin
        st_q  <= spsr_q[cbank[BW-1:0]];
        tgt_q <= lr_q[cbank[BW-1:0]] - XLEN'({ret_adj_i, 2'b00});
      end else if (wr_i) begin
        st_q <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && take) begin
      spsr_q[tbank[BW-1:0]] <= st_q;
      lr_q[tbank[BW-1:0]]   <= link;
    end
  end

  assign status_o   = st_q;
  assign saved_o    = cbank[BW] ? spsr_q[cbank[BW-1:0]] : '0;
  assign link_o     = cbank[BW] ? lr_q[cbank[BW-1:0]] : '0;
  assign entry_o    = entry_q;
  assign exc_code_o = code_q;
  assign return_o   = return_q;
  assign ret_err_o  = err_q;
  assign target_o   = tgt_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         entry_o,
  input logic         return_o,
  input logic         ret_err_o,
  input logic [2:0]   exc_code_o,
  input logic [W-1:0] status_o
);

  a_r11_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({entry_o, return_o, ret_err_o}));

  a_r3_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (status_o[7] && !status_o[5]));

  a_r4_fiq_sets_f: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && exc_code_o == 3'd7) |-> status_o[6]);

  a_r4_f_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && exc_code_o != 3'd0 && exc_code_o != 3'd7) |-> (status_o[6] == $past(status_o[6])));

  a_r5_a_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && (exc_code_o == 3'd1 || exc_code_o == 3'd2)) |-> (status_o[8] == $past(status_o[8])));

  a_r8_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && exc_code_o == 3'd6) |-> !$past(status_o[7]));

  a_r13_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err_o |-> $stable(status_o));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.W(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .entry_o(entry_o), .return_o(return_o),
  .ret_err_o(ret_err_o), .exc_code_o(exc_code_o), .status_o(status_o)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] pc = '0, va = '0, wd = '0;
  logic        exv = 0, bnd = 0, und = 0, swi = 0, pab = 0, dab = 0, irq = 0, fiq = 0;
  logic        hv = 0, en = 1, ve = 0, ret = 0, wr = 0;
  logic [1:0]  adj = '0;

  logic [31:0] status_o, saved_o, link_o, target_o;
  logic        entry_o, return_o, ret_err_o;
  logic [2:0]  exc_code_o;

  int checks = 0, errs = 0;
  logic [31:0] st, sv_st, sv_lr;

  exc_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .exec_i(exv), .bnd_i(bnd),
    .und_i(und), .swi_i(swi), .pabt_i(pab), .dabt_i(dab), .irq_i(irq), .fiq_i(fiq),
    .hivec_i(hv), .endian_i(en), .vic_en_i(ve), .vic_addr_i(va),
    .ret_i(ret), .ret_adj_i(adj), .wr_i(wr), .wr_data_i(wd),
    .status_o(status_o), .saved_o(saved_o), .link_o(link_o), .entry_o(entry_o),
    .exc_code_o(exc_code_o), .return_o(return_o), .ret_err_o(ret_err_o), .target_o(target_o)
  );

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s: got %h expected %h", r, a, e);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr;
    exv = 0; bnd = 0; und = 0; swi = 0; pab = 0; dab = 0; irq = 0; fiq = 0;
    ret = 0; wr = 0; adj = '0;
  endtask

  function automatic logic [4:0] mode_of(input logic [2:0] c);
    case (c)
      3'd1: mode_of = 5'b11011;
      3'd3, 3'd4: mode_of = 5'b10111;
      3'd6: mode_of = 5'b10010;
      3'd7: mode_of = 5'b10001;
      default: mode_of = 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] exp_st(input logic [31:0] p, input logic [2:0] c, input logic e);
    logic [31:0] s;
    s = p;
    s[4:0] = mode_of(c);
    s[5] = 1'b0;
    s[7] = 1'b1;
    s[9] = e;
    if (c == 3'd7) s[6] = 1'b1;
    if (c != 3'd1 && c != 3'd2) s[8] = 1'b1;
    return s;
  endfunction

  task automatic t_reset(input logic h, input logic e);
    rst_n = 0; hv = h; en = e; clr;
    step; step;
    chk("R1 reset entry", {31'd0, entry_o}, 32'd1);
    chk("R1 reset code", {29'd0, exc_code_o}, 32'd0);
    chk("R1 reset vector", target_o, h ? 32'hFFFF0000 : 32'h0);
    chk("R1 reset status", status_o, 32'h1D3 | ({31'd0, e} << 9));
    rst_n = 1;
    step;
    chk("R1 after release", {31'd0, entry_o}, 32'd0);
    st = 32'h1D3 | ({31'd0, e} << 9);
  endtask

  task automatic t_write(input logic [31:0] v);
    wr = 1; wd = v;
    step; clr;
    chk("R14 status write", status_o, v);
    st = v;
  endtask

  // also: bit0 = return request, bit5 = status write, others = extra request lines by code
  task automatic take_exc(input logic [2:0] c, input logic [31:0] a, input logic [7:0] also, input string r);
    logic [7:0] m;
    logic [31:0] prev, ex, lr, vec;
    prev = st;
    m = also | (8'd1 << c);
    pc = a;
    if (m[1]) begin und = 1; exv = 1; end
    if (m[2]) begin swi = 1; exv = 1; end
    if (m[3]) begin pab = 1; exv = 1; end
    if (m[4]) dab = 1;
    if (m[6]) begin irq = 1; bnd = 1; end
    if (m[7]) begin fiq = 1; bnd = 1; end
    if (m[0]) begin ret = 1; adj = 2'd1; end
    if (m[5]) begin wr = 1; wd = 32'h0; end
    step; clr;
    ex  = exp_st(prev, c, en);
    lr  = (c == 3'd4) ? a + 32'd8 : a + 32'd4;
    vec = (ve && c >= 3'd6) ? va : ((hv ? 32'hFFFF0000 : 32'h0) + {27'd0, c, 2'b00});
    chk($sformatf("%s R11 entry", r), {31'd0, entry_o}, 32'd1);
    chk($sformatf("%s R11 return dropped", r), {31'd0, return_o}, 32'd0);
    chk($sformatf("%s R2 code", r), {29'd0, exc_code_o}, {29'd0, c});
    chk($sformatf("%s R2 R9 vector", r), target_o, vec);
    chk($sformatf("%s R3 R4 R5 status", r), status_o, ex);
    chk($sformatf("%s R7 saved", r), saved_o, prev);
    chk($sformatf("%s R6 link", r), link_o, lr);
    st = ex; sv_st = prev; sv_lr = lr;
  endtask

  task automatic no_take(input string r);
    step; clr;
    chk($sformatf("%s no entry", r), {31'd0, entry_o}, 32'd0);
    chk($sformatf("%s status kept", r), status_o, st);
  endtask

  task automatic t_ret(input logic [1:0] a);
    ret = 1; adj = a;
    step; clr;
    chk("R12 return pulse", {31'd0, return_o}, 32'd1);
    chk("R12 return target", target_o, sv_lr - {28'd0, a, 2'b00});
    chk("R12 status restored", status_o, sv_st);
    st = sv_st;
  endtask

  task automatic t_ret_err(input logic [1:0] a);
    ret = 1; adj = a;
    step; clr;
    chk("R13 error pulse", {31'd0, ret_err_o}, 32'd1);
    chk("R13 no return", {31'd0, return_o}, 32'd0);
    chk("R13 status kept", status_o, st);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset(1'b1, 1'b0);
    t_reset(1'b0, 1'b1);

    t_write(32'h0010_0230);
    chk("R7 user mode has no bank", saved_o, 32'h0);

    take_exc(3'd1, 32'h1000, 8'h00, "und");
    t_ret(2'd0);

    hv = 1;
    take_exc(3'd2, 32'h2000, 8'h00, "swi hivec");
    hv = 0;
    t_ret(2'd1);

    pab = 1; exv = 0; pc = 32'h3000;
    no_take("R10 flushed prefetch abort");
    und = 1; exv = 0;
    no_take("R10 flushed undefined");
    take_exc(3'd3, 32'h3000, 8'h00, "pabt");
    t_ret(2'd1);

    take_exc(3'd4, 32'h4000, 8'h00, "dabt");
    t_ret(2'd2);

    irq = 1; bnd = 0;
    no_take("R8 irq off boundary");
    en = 0;
    take_exc(3'd6, 32'h5000, 8'h00, "irq endian0");
    en = 1;
    t_ret(2'd1);

    take_exc(3'd7, 32'h6000, 8'h40, "R8 fiq over irq");
    irq = 1; bnd = 1;
    no_take("R8 irq masked in fiq handler");
    t_ret(2'd1);

    ve = 1; va = 32'hABCD_0100;
    take_exc(3'd6, 32'h7000, 8'h00, "R9 vectored irq");
    t_ret(2'd1);
    take_exc(3'd7, 32'h7100, 8'h00, "R9 vectored fiq");
    t_ret(2'd1);
    ve = 0;

    take_exc(3'd4, 32'h8000, 8'h82, "R11 dabt over fiq und");
    t_ret(2'd2);
    take_exc(3'd3, 32'h8100, 8'h06, "R11 pabt over und swi");
    t_ret(2'd1);
    take_exc(3'd1, 32'h8200, 8'h05, "R11 und over swi ret");
    t_ret(2'd0);
    take_exc(3'd2, 32'h8300, 8'h20, "R11 swi over write");
    t_ret(2'd1);

    t_ret_err(2'd1);
    take_exc(3'd2, 32'h9000, 8'h00, "swi before bad adj");
    t_ret_err(2'd3);
    t_ret(2'd1);

    t_write(32'h0000_0050);
    fiq = 1; bnd = 1;
    no_take("R8 fiq masked by bit6");
    take_exc(3'd6, 32'hA000, 8'h80, "R8 irq while fiq masked");
    t_ret(2'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule